// File: doc/BRIEF.md
# Per-Drive Status Register Bank

This block keeps one 16-bit status word for each drive behind a disk controller. A sequencer outside the block reports events such as a finished seek, an address fault, a data overrun, a cylinder boundary, an init request or a drive being attached or detached. The block turns each event into set and clear requests on the addressed drive's word. The host reads the words back through a small request port, and the block answers one cycle later.

A status read returns the addressed word with bit 0 replaced by an error summary computed from the other bits. The same read clears the one-shot flags of that word. An attention read returns one bit per drive, taken from each drive's attention flag. It can either load that bitmap or OR it into a word the host supplies.

A soft controller clear keeps the first-seek history and sets not-ready on every drive that is not attached. A hardware reset clears everything.

The response logic is a three-state machine:
- ST_IDLE: no response.
- ST_STATUS: a status word is being presented.
- ST_ATTN: an attention bitmap is being presented.

From any state, a status request moves to ST_STATUS, either attention request moves to ST_ATTN, and no request returns to ST_IDLE. Each response lasts exactly one cycle unless a new request follows it.

Top module: `drive_status_bank`

## Requirements
- R1: While `rst_n` is low, every status word is cleared and `rsp_valid` is 0. The first reads after reset return 0x0000.
- R2: An event (`ev_valid`, `ev_drive`, `ev_set`, `ev_clr`) changes only the addressed drive's word: bits in `ev_set` are set and bits in `ev_clr` are cleared. Bit 7 (unused) and bit 0 (summary) are never stored, so they are always 0 in the stored word, and a status read shows bit 7 as 0.
- R3: When a bit is both set and cleared in the same cycle, setting wins. The clear may come from `ev_clr`, from attach or detach, or from a status read of that drive.
- R4: `req_op`=1 (status read of `req_drive`) gives `rsp_valid`=1 and `rsp_attn`=0 in the next cycle. `rsp_data` then holds that drive's word as it was before the request edge.
- R5: In a status response, bit 0 is 1 exactly when the word has any bit of mask 0xFF6A set. That mask covers attention 15, first-seek 14, overrun 13, rw-unsafe 12, access-unsafe 11, hunting 10, seek-incomplete 9, seek-error 8, not-ready 6, end-of-cylinder 5, flagged 3 and data-error 1. Address error (bit 4) and busy (bit 2) do not contribute.
- R6: A status read clears attention, end-of-cylinder, address error, flagged and data error (mask 0x803A) in the drive that was read. All other bits are kept, and other drives are unchanged.
- R7: `req_op`=2 (attention load) gives, one cycle later, `rsp_valid`=1 and `rsp_attn`=1. `rsp_data` bit i is drive i's bit 15, and all bits from NUM_DRIVES upward are 0. The attention read clears nothing.
- R8: `req_op`=3 (attention merge) responds like R7, but `rsp_data` is the attention bitmap ORed with `merge_in`.
- R9: An `attach` pulse sets first-seek (bit 14) and clears not-ready (bit 6) of its drive. A `detach` pulse sets not-ready and clears first-seek.
- R10: `soft_clr` leaves each word holding only its first-seek bit, plus not-ready where the drive's `attached` bit is 0. It overrides every event in the same cycle.
- R11: A cycle with `req_op`=0 gives `rsp_valid`=0 in the next cycle. Back-to-back requests give back-to-back responses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_clr | input | 1 | Controller clear (R10) |
| attached | input | NUM_DRIVES | Level: drive currently attached |
| attach | input | NUM_DRIVES | Pulse per drive: drive became attached |
| detach | input | NUM_DRIVES | Pulse per drive: drive was detached |
| ev_valid | input | 1 | Sequencer event strobe |
| ev_drive | input | DRV_W | Drive addressed by the event |
| ev_set | input | 16 | Bits to set |
| ev_clr | input | 16 | Bits to clear |
| req_op | input | 2 | 0 none, 1 status, 2 attention load, 3 attention merge |
| req_drive | input | DRV_W | Drive for a status read |
| merge_in | input | 16 | Word ORed with the bitmap on merge |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_attn | output | 1 | Response is an attention bitmap |
| rsp_data | output | 16 | Response word |

## Verification
Stored words are visible only through status reads. A wrong set, clear or priority decision therefore shows up in the first status read of that drive after the event, one cycle after the request. A missing read-clear shows up on the second read, where the flags that should have gone reappear together with a set summary bit. A stuck state-machine state shows up as `rsp_valid` or `rsp_attn` being wrong in the cycle right after a request, or in the cycle right after an idle cycle.

// File: rtl/dsb_pkg.sv
package dsb_pkg;

    localparam int WORD_W = 16;

    localparam int B_ATTN  = 15;
    localparam int B_FIRST = 14;
    localparam int B_OVRN  = 13;
    localparam int B_RWUNS = 12;
    localparam int B_ACUNS = 11;
    localparam int B_HUNT  = 10;
    localparam int B_SKINC = 9;
    localparam int B_SKERR = 8;
    localparam int B_SPARE = 7;
    localparam int B_NRDY  = 6;
    localparam int B_EOCYL = 5;
    localparam int B_ADDR  = 4;
    localparam int B_FLAG  = 3;
    localparam int B_BUSY  = 2;
    localparam int B_DATA  = 1;
    localparam int B_SUM   = 0;

    localparam logic [WORD_W-1:0] ONE = {{(WORD_W-1){1'b0}}, 1'b1};

    localparam logic [WORD_W-1:0] STORE_MASK =
        ~((ONE << B_SPARE) | (ONE << B_SUM));

    localparam logic [WORD_W-1:0] SUMMARY_MASK =
        (ONE << B_ATTN) | (ONE << B_FIRST) | (ONE << B_OVRN) | (ONE << B_RWUNS) |
        (ONE << B_ACUNS) | (ONE << B_HUNT) | (ONE << B_SKINC) | (ONE << B_SKERR) |
        (ONE << B_NRDY) | (ONE << B_EOCYL) | (ONE << B_FLAG) | (ONE << B_DATA);

    localparam logic [WORD_W-1:0] READ_CLR_MASK =
        (ONE << B_ATTN) | (ONE << B_EOCYL) | (ONE << B_ADDR) |
        (ONE << B_FLAG) | (ONE << B_DATA);

    typedef enum logic [1:0] {
        OP_NONE       = 2'd0,
        OP_STATUS     = 2'd1,
        OP_ATTN_LOAD  = 2'd2,
        OP_ATTN_MERGE = 2'd3
    } req_op_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_STATUS = 2'd1,
        ST_ATTN   = 2'd2
    } rsp_state_e;

    function automatic logic [WORD_W-1:0] with_summary(input logic [WORD_W-1:0] w);
        logic [WORD_W-1:0] r;
        r = w;
        r[B_SUM] = |(w & SUMMARY_MASK);
        return r;
    endfunction

endpackage

// File: rtl/drive_status_word.sv
module drive_status_word
    import dsb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_clr,
    input  logic              attached,
    input  logic [WORD_W-1:0] set_bits,
    input  logic [WORD_W-1:0] clr_bits,
    output logic [WORD_W-1:0] word
);

    logic [WORD_W-1:0] keep_on_clear;
    logic [WORD_W-1:0] updated;

    always_comb begin
        keep_on_clear = word & (ONE << B_FIRST);
        if (!attached) begin
            keep_on_clear = keep_on_clear | (ONE << B_NRDY);
        end
        updated = ((word & ~clr_bits) | set_bits) & STORE_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word <= '0;
        end else if (soft_clr) begin
            word <= keep_on_clear;
        end else begin
            word <= updated;
        end
    end

endmodule

// File: rtl/dsb_reader.sv
module dsb_reader
    import dsb_pkg::*;
#(
    parameter int NUM_DRIVES = 4,
    localparam int DRV_W = (NUM_DRIVES > 1) ? $clog2(NUM_DRIVES) : 1
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [1:0]                          req_op,
    input  logic [DRV_W-1:0]                    req_drive,
    input  logic [WORD_W-1:0]                   merge_in,
    input  logic [NUM_DRIVES-1:0][WORD_W-1:0]   words,
    output logic                                rsp_valid,
    output logic                                rsp_attn,
    output logic [WORD_W-1:0]                   rsp_data
);

    rsp_state_e        state, state_nx;
    logic [WORD_W-1:0] data_q, data_nx;
    logic [WORD_W-1:0] attn_map;

    always_comb begin
        attn_map = '0;
        for (int i = 0; i < NUM_DRIVES; i++) begin
            attn_map[i] = words[i][B_ATTN];
        end
    end

    always_comb begin
        state_nx = ST_IDLE;
        data_nx  = data_q;
        unique case (req_op_e'(req_op))
            OP_NONE: begin
                state_nx = ST_IDLE;
            end
            OP_STATUS: begin
                state_nx = ST_STATUS;
                data_nx  = with_summary(words[req_drive]);
            end
            OP_ATTN_LOAD: begin
                state_nx = ST_ATTN;
                data_nx  = attn_map;
            end
            OP_ATTN_MERGE: begin
                state_nx = ST_ATTN;
                data_nx  = attn_map | merge_in;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            data_q <= '0;
        end else begin
            state  <= state_nx;
            data_q <= data_nx;
        end
    end

    always_comb begin
        rsp_valid = 1'b0;
        rsp_attn  = 1'b0;
        rsp_data  = '0;
        unique case (state)
            ST_IDLE: begin
                rsp_valid = 1'b0;
            end
            ST_STATUS: begin
                rsp_valid = 1'b1;
                rsp_data  = data_q;
            end
            ST_ATTN: begin
                rsp_valid = 1'b1;
                rsp_attn  = 1'b1;
                rsp_data  = data_q;
            end
            default: begin
                rsp_valid = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/drive_status_bank.sv
module drive_status_bank
    import dsb_pkg::*;
#(
    parameter int NUM_DRIVES = 4,
    localparam int DRV_W = (NUM_DRIVES > 1) ? $clog2(NUM_DRIVES) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  soft_clr,
    input  logic [NUM_DRIVES-1:0] attached,
    input  logic [NUM_DRIVES-1:0] attach,
    input  logic [NUM_DRIVES-1:0] detach,
    input  logic                  ev_valid,
    input  logic [DRV_W-1:0]      ev_drive,
    input  logic [WORD_W-1:0]     ev_set,
    input  logic [WORD_W-1:0]     ev_clr,
    input  logic [1:0]            req_op,
    input  logic [DRV_W-1:0]      req_drive,
    input  logic [WORD_W-1:0]     merge_in,
    output logic                  rsp_valid,
    output logic                  rsp_attn,
    output logic [WORD_W-1:0]     rsp_data
);

    logic [NUM_DRIVES-1:0][WORD_W-1:0] words;

    for (genvar g = 0; g < NUM_DRIVES; g++) begin : g_drive
        logic [WORD_W-1:0] set_bits, clr_bits;
        logic              ev_hit, rd_hit;

        always_comb begin
            ev_hit   = ev_valid && (ev_drive == DRV_W'(g));
            rd_hit   = (req_op == OP_STATUS) && (req_drive == DRV_W'(g));
            set_bits = '0;
            clr_bits = '0;
            if (ev_hit) begin
                set_bits = set_bits | ev_set;
                clr_bits = clr_bits | ev_clr;
            end
            if (rd_hit) begin
                clr_bits = clr_bits | READ_CLR_MASK;
            end
            if (attach[g]) begin
                set_bits = set_bits | (ONE << B_FIRST);
                clr_bits = clr_bits | (ONE << B_NRDY);
            end
            if (detach[g]) begin
                set_bits = set_bits | (ONE << B_NRDY);
                clr_bits = clr_bits | (ONE << B_FIRST);
            end
        end

        drive_status_word u_word (
            .clk      (clk),
            .rst_n    (rst_n),
            .soft_clr (soft_clr),
            .attached (attached[g]),
            .set_bits (set_bits),
            .clr_bits (clr_bits),
            .word     (words[g])
        );
    end

    dsb_reader #(.NUM_DRIVES(NUM_DRIVES)) u_reader (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_op    (req_op),
        .req_drive (req_drive),
        .merge_in  (merge_in),
        .words     (words),
        .rsp_valid (rsp_valid),
        .rsp_attn  (rsp_attn),
        .rsp_data  (rsp_data)
    );

endmodule

// File: rtl/dsb_checker.sv
module dsb_checker
    import dsb_pkg::*;
#(
    parameter int NUM_DRIVES = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        req_op,
    input logic              rsp_valid,
    input logic              rsp_attn,
    input logic [WORD_W-1:0] rsp_data
);

    assert_status_reply_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_op == OP_STATUS) |=> (rsp_valid && !rsp_attn));

    assert_attn_reply_R7: assert property (@(posedge clk) disable iff (!rst_n)
        req_op[1] |=> (rsp_valid && rsp_attn));

    assert_attn_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_op == OP_ATTN_LOAD) |=> ((rsp_data >> NUM_DRIVES) == '0));

    assert_idle_return_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_op == OP_NONE) |=> !rsp_valid);

    assert_summary_on_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_attn && ((rsp_data & SUMMARY_MASK) != '0)) |-> rsp_data[B_SUM]);

    assert_summary_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_attn && ((rsp_data & SUMMARY_MASK) == '0)) |-> !rsp_data[B_SUM]);

    assert_spare_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_attn) |-> !rsp_data[B_SPARE]);

endmodule

bind drive_status_bank dsb_checker #(.NUM_DRIVES(NUM_DRIVES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_op    (req_op),
    .rsp_valid (rsp_valid),
    .rsp_attn  (rsp_attn),
    .rsp_data  (rsp_data)
);

// File: tb/drive_status_bank_tb.sv
module drive_status_bank_tb;

    localparam int N = 4;
    localparam int DW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          soft_clr = 1'b0;
    logic [N-1:0]  attached = '0, attach = '0, detach = '0;
    logic          ev_valid = 1'b0;
    logic [DW-1:0] ev_drive = '0;
    logic [15:0]   ev_set = '0, ev_clr = '0;
    logic [1:0]    req_op = 2'd0;
    logic [DW-1:0] req_drive = '0;
    logic [15:0]   merge_in = '0;
    logic          rsp_valid, rsp_attn;
    logic [15:0]   rsp_data;

    int checks = 0, fails = 0;
    bit done = 0;

    always #2 clk = ~clk;

    drive_status_bank #(.NUM_DRIVES(N)) u_dut (.*);

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic read_status(input int d, input string req, input logic [15:0] exp);
        @(negedge clk);
        req_op = 2'd1; req_drive = DW'(d);
        @(negedge clk);
        req_op = 2'd0;
        chk({req, " valid/kind"}, {14'd0, rsp_valid, rsp_attn}, 16'h0002);
        chk(req, rsp_data, exp);
    endtask

    task automatic event_one(input int d, input logic [15:0] s, input logic [15:0] c);
        @(negedge clk);
        ev_valid = 1'b1; ev_drive = DW'(d); ev_set = s; ev_clr = c;
        @(negedge clk);
        ev_valid = 1'b0; ev_set = '0; ev_clr = '0;
    endtask

    task automatic t_reset;
        chk("R1 rsp_valid in reset", {15'd0, rsp_valid}, 16'h0);
        @(negedge clk); rst_n = 1'b1;
        for (int d = 0; d < N; d++) read_status(d, "R1 word after reset", 16'h0000);
    endtask

    task automatic t_isolation;
        event_one(2, 16'h0081, 16'h0);
        read_status(2, "R2 bits 0 and 7 not stored", 16'h0000);
        event_one(1, 16'h2000, 16'h0);
        read_status(0, "R2 other drive untouched", 16'h0000);
        read_status(1, "R2 overrun set", 16'h2001);
        event_one(1, 16'h0, 16'h2000);
        read_status(1, "R2 overrun cleared", 16'h0000);
    endtask

    task automatic t_summary;
        event_one(3, 16'h0014, 16'h0);
        read_status(3, "R5 addr err and busy excluded", 16'h0014);
        read_status(3, "R6 addr err cleared, busy kept", 16'h0004);
        event_one(3, 16'h0, 16'h0004);
    endtask

    task automatic t_read_clear;
        event_one(0, 16'hFFFE, 16'h0);
        read_status(0, "R6 full word before read", 16'hFF7F);
        read_status(0, "R6 after read clear", 16'h7F45);
        read_status(1, "R6 other drive unchanged", 16'h0000);
        event_one(0, 16'h0, 16'hFFFF);
    endtask

    task automatic t_priority;
        event_one(2, 16'h0100, 16'h0100);
        read_status(2, "R3 set beats ev_clr", 16'h0101);
        // attention set in the same cycle as a status read of that drive
        @(negedge clk);
        ev_valid = 1'b1; ev_drive = 2'd2; ev_set = 16'h8000;
        req_op = 2'd1; req_drive = 2'd2;
        @(negedge clk);
        ev_valid = 1'b0; ev_set = '0; req_op = 2'd0;
        chk("R3 read shows pre-edge word", rsp_data, 16'h0101);
        read_status(2, "R3 attention kept over read-clear", 16'h8101);
        event_one(2, 16'h0, 16'h0100);
    endtask

    task automatic t_attention;
        event_one(1, 16'h8000, 16'h0);
        event_one(3, 16'h8000, 16'h0);
        @(negedge clk); req_op = 2'd2;
        @(negedge clk); req_op = 2'd0;
        chk("R7 attention load kind", {14'd0, rsp_valid, rsp_attn}, 16'h0003);
        chk("R7 attention bitmap", rsp_data, 16'h000A);
        @(negedge clk); req_op = 2'd3; merge_in = 16'hF000;
        @(negedge clk); req_op = 2'd0; merge_in = '0;
        chk("R8 attention merge", rsp_data, 16'hF00A);
        read_status(1, "R7 attention read clears nothing", 16'h8001);
        read_status(3, "R6 clears attention", 16'h8001);
    endtask

    task automatic t_attach;
        @(negedge clk); detach = 4'b0100;
        @(negedge clk); detach = '0;
        read_status(2, "R9 detach", 16'h0041);
        @(negedge clk); attach = 4'b0100;
        @(negedge clk); attach = '0;
        read_status(2, "R9 attach", 16'h4001);
    endtask

    task automatic t_soft_clr;
        event_one(0, 16'h6000, 16'h0);
        @(negedge clk);
        attached = 4'b0101; soft_clr = 1'b1;
        ev_valid = 1'b1; ev_drive = 2'd1; ev_set = 16'h2000;
        @(negedge clk);
        soft_clr = 1'b0; ev_valid = 1'b0; ev_set = '0;
        read_status(0, "R10 first-seek kept", 16'h4001);
        read_status(1, "R10 not attached, event overridden", 16'h0041);
        read_status(2, "R10 attached keeps first-seek", 16'h4001);
        read_status(3, "R10 not attached", 16'h0041);
    endtask

    task automatic t_back_to_back;
        @(negedge clk); req_op = 2'd1; req_drive = 2'd0;
        @(negedge clk); req_op = 2'd2;
        chk("R11 first of pair", rsp_data, 16'h4001);
        @(negedge clk); req_op = 2'd0;
        chk("R11 second of pair kind", {14'd0, rsp_valid, rsp_attn}, 16'h0003);
        @(negedge clk);
        chk("R11 idle after pair", {15'd0, rsp_valid}, 16'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_isolation();
        t_summary();
        t_read_clear();
        t_priority();
        t_attention();
        t_attach();
        t_soft_clr();
        t_back_to_back();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule